// File: doc/BRIEF.md
# Write-Triggered Expansion Window Controller

This block is the control logic of a mass-memory expansion that sits on a host bus with 16-bit addresses and 8-bit data. It claims the two 256-byte I/O pages at $DE00 and $DF00. Software changes its configuration by writing to fixed trigger addresses. For most triggers the value written does not matter. The only exception is the two page-latch bytes, which store the data value. Software cannot read the configuration back.

When the controller is off, the whole $DE00–$DFFF range belongs to the pass-through port. If the direct strap is set, that range belongs to the auxiliary expansion port instead. When the controller is on, the $DE00 page becomes a window onto one of four sources:
- internal 8 KB static RAM;
- a RAM card with a 24-bit address, paged in 256-byte pages;
- the auxiliary expansion port;
- the pass-through port.

In the $DF00 page, the first eleven registers are routed to the auxiliary port. A four-register parallel interface chip is also mapped in that page. The block drives one chip-select per target, the RAM card and static RAM addresses, the parallel register index, and a DOS ROM enable.

Top module: `exp_window_ctrl`

## Requirements
- R1: After reset the controller is off, the window source is static RAM, the card page is $0000 and the ROM enable is low.
- R2: A write of any value to $DF7E turns the controller on, and a write of any value to $DF7F turns it off. The new state takes effect on the bus cycle after the write. Turning the controller off and on again keeps the window source.
- R3: While off, any bus cycle in $DE00–$DFFF asserts only cs_pass_o. If direct_i is high, it asserts only cs_aux_o instead.
- R4: While on, a write to $DFC0+k for k = 0..3 selects the window source. The values are k=0 static RAM, k=1 RAM card, k=2 auxiliary port and k=3 pass-through. The data value is ignored. The same writes made while off have no effect. Accesses to $DE00–$DEFF assert the chip-select of the selected source.
- R5: While on, a write to $DFA0 stores the data byte as page bits 15:8 of the card address. A write to $DFA1 stores it as page bits 23:16. card_addr_o equals {page, addr_i[7:0]}.
- R6: sram_addr_o equals {5'b0, addr_i[7:0]}.
- R7: While on, a write to $DF60 sets rom_en_o and a write to $DF70 clears it. The same writes while off have no effect.
- R8: While on, accesses to $DF00–$DF0A assert cs_aux_o. $DF0B is not routed there.
- R9: While on, accesses to $DF40–$DF43 assert cs_pio_o, and pio_reg_o equals addr_i[1:0].
- R10: Read cycles at trigger addresses change no state.
- R11: At most one chip-select is high at a time. None is high when no bus cycle is in progress or when the address lies outside $DE00–$DFFF. While on, other $DF00-page addresses assert none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Host address |
| data_i | input | 8 | Host write data |
| wr_i | input | 1 | Write cycle in progress |
| rd_i | input | 1 | Read cycle in progress |
| direct_i | input | 1 | Direct strap: routes I/O to the auxiliary port while off |
| cs_sram_o | output | 1 | Internal static RAM select |
| cs_card_o | output | 1 | RAM card select |
| cs_aux_o | output | 1 | Auxiliary expansion port select |
| cs_pass_o | output | 1 | Pass-through port select |
| cs_pio_o | output | 1 | Parallel interface chip select |
| pio_reg_o | output | 2 | Parallel chip register index |
| card_addr_o | output | 24 | RAM card byte address |
| sram_addr_o | output | 13 | Static RAM byte address |
| rom_en_o | output | 1 | DOS ROM enable |

## Verification
The hardest cases to reach are writes that must be ignored: source, page and ROM triggers made while the controller is off, and reads of trigger addresses. These leave no mark until a later configuration exposes them. The stimulus issues those writes and reads first. It then turns the controller on and sweeps all 512 I/O addresses, where a wrongly latched state would show up as a wrong chip-select or address. The sweep is repeated for every window source, both strap settings and two page values. Each sweep is compared against a model of the state built from the write history.

// File: rtl/exp_win_pkg.sv
package exp_win_pkg;
  typedef enum logic [1:0] {
    SRC_SRAM = 2'd0,
    SRC_CARD = 2'd1,
    SRC_AUX  = 2'd2,
    SRC_PASS = 2'd3
  } win_src_e;

  localparam logic [15:0] ON_ADDR      = 16'hDF7E;
  localparam logic [15:0] OFF_ADDR     = 16'hDF7F;
  localparam logic [15:0] SRC_BASE     = 16'hDFC0;
  localparam logic [15:0] PAGE_BASE    = 16'hDFA0;
  localparam logic [15:0] ROM_ON_ADDR  = 16'hDF60;
  localparam logic [15:0] ROM_OFF_ADDR = 16'hDF70;
  localparam logic [7:0]  AUX_LAST     = 8'h0A;
  localparam logic [7:0]  PIO_BASE     = 8'h40;
  localparam logic [6:0]  IO_TAG       = 7'h6F;  // addr[15:9] of $DE00-$DFFF
endpackage

// File: rtl/ewc_trig_decode.sv
module ewc_trig_decode
  import exp_win_pkg::*;
#(
  parameter int AW         = 16,
  parameter int PAGE_BYTES = 2
) (
  input  logic [AW-1:0]         addr_i,
  input  logic                  wr_i,
  input  logic                  active_i,
  output logic                  on_o,
  output logic                  off_o,
  output logic                  src_wr_o,
  output win_src_e              src_sel_o,
  output logic [PAGE_BYTES-1:0] pg_wr_o,
  output logic                  rom_on_o,
  output logic                  rom_off_o
);
  logic cfg_wr;
  assign cfg_wr    = wr_i && active_i;
  assign on_o      = wr_i && (addr_i == ON_ADDR);
  assign off_o     = wr_i && (addr_i == OFF_ADDR);
  assign src_wr_o  = cfg_wr && (addr_i[AW-1:2] == SRC_BASE[AW-1:2]);
  assign src_sel_o = win_src_e'(addr_i[1:0]);
  assign rom_on_o  = cfg_wr && (addr_i == ROM_ON_ADDR);
  assign rom_off_o = cfg_wr && (addr_i == ROM_OFF_ADDR);

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_pg
    assign pg_wr_o[g] = cfg_wr && (addr_i == PAGE_BASE + AW'(g));
  end
endmodule

// File: rtl/ewc_mode_regs.sv
module ewc_mode_regs
  import exp_win_pkg::*;
#(
  parameter int DW         = 8,
  parameter int PAGE_BYTES = 2,
  localparam int PW        = DW * PAGE_BYTES
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DW-1:0]         data_i,
  input  logic                  wr_i,
  input  logic                  on_i,
  input  logic                  off_i,
  input  logic                  src_wr_i,
  input  win_src_e              src_sel_i,
  input  logic [PAGE_BYTES-1:0] pg_wr_i,
  input  logic                  rom_on_i,
  input  logic                  rom_off_i,
  output logic                  active_o,
  output win_src_e              src_o,
  output logic [PW-1:0]         page_o,
  output logic                  rom_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      src_o    <= SRC_SRAM;
      rom_en_o <= 1'b0;
    end else begin
      if (on_i)          active_o <= 1'b1;
      else if (off_i)    active_o <= 1'b0;
      if (src_wr_i)      src_o    <= src_sel_i;
      if (rom_on_i)      rom_en_o <= 1'b1;
      else if (rom_off_i) rom_en_o <= 1'b0;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_pg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        page_o[g*DW +: DW] <= '0;
      else if (pg_wr_i[g]) page_o[g*DW +: DW] <= data_i;
    end

    // R5
    pg_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pg_wr_i[g] |=> page_o[g*DW +: DW] == $past(data_i));
  end

  // R2
  turn_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_i |=> active_o);
  // R2
  turn_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_i && !on_i) |=> !active_o);
  // R4
  src_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_wr_i |=> src_o == $past(src_sel_i));
  // R7
  rom_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_on_i |=> rom_en_o);
  // R10
  no_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable({active_o, src_o, page_o, rom_en_o}));
endmodule

// File: rtl/ewc_route.sv
module ewc_route
  import exp_win_pkg::*;
#(
  parameter int AW      = 16,
  parameter int WIN_W   = 8,
  parameter int PAGE_W  = 16,
  parameter int SRAM_AW = 13,
  localparam int SRAM_PG_W = SRAM_AW - WIN_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [AW-1:0]           addr_i,
  input  logic                    bus_i,
  input  logic                    active_i,
  input  logic                    direct_i,
  input  win_src_e                src_i,
  input  logic [PAGE_W-1:0]       page_i,
  output logic                    cs_sram_o,
  output logic                    cs_card_o,
  output logic                    cs_aux_o,
  output logic                    cs_pass_o,
  output logic                    cs_pio_o,
  output logic [1:0]              pio_reg_o,
  output logic [PAGE_W+WIN_W-1:0] card_addr_o,
  output logic [SRAM_AW-1:0]      sram_addr_o
);
  logic in_io;
  logic [3:0] win_hit;

  assign in_io = addr_i[AW-1:9] == IO_TAG;

  for (genvar g = 0; g < 4; g++) begin : g_win
    assign win_hit[g] = src_i == win_src_e'(g);
  end

  always_comb begin
    cs_sram_o = 1'b0;
    cs_card_o = 1'b0;
    cs_aux_o  = 1'b0;
    cs_pass_o = 1'b0;
    cs_pio_o  = 1'b0;
    if (bus_i && in_io) begin
      if (!active_i) begin
        cs_aux_o  = direct_i;
        cs_pass_o = !direct_i;
      end else if (!addr_i[8]) begin
        cs_sram_o = win_hit[SRC_SRAM];
        cs_card_o = win_hit[SRC_CARD];
        cs_aux_o  = win_hit[SRC_AUX];
        cs_pass_o = win_hit[SRC_PASS];
      end else if (addr_i[7:0] <= AUX_LAST) begin
        cs_aux_o = 1'b1;
      end else if (addr_i[7:2] == PIO_BASE[7:2]) begin
        cs_pio_o = 1'b1;
      end
    end
  end

  assign pio_reg_o   = addr_i[1:0];
  assign card_addr_o = {page_i, addr_i[WIN_W-1:0]};
  assign sram_addr_o = {{SRAM_PG_W{1'b0}}, addr_i[WIN_W-1:0]};

  // R11
  one_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cs_sram_o, cs_card_o, cs_aux_o, cs_pass_o, cs_pio_o}));
  // R11
  outside_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_i || !in_io) |-> !(cs_sram_o || cs_card_o || cs_aux_o || cs_pass_o || cs_pio_o));
  // R3
  off_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_i && in_io && !active_i) |-> (direct_i ? cs_aux_o : cs_pass_o));
endmodule

// File: rtl/exp_window_ctrl.sv
module exp_window_ctrl
  import exp_win_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int PAGE_BYTES = 2,
  parameter int SRAM_AW    = 13,
  localparam int PAGE_W    = DW * PAGE_BYTES,
  localparam int CARD_AW   = PAGE_W + DW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      data_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic               direct_i,
  output logic               cs_sram_o,
  output logic               cs_card_o,
  output logic               cs_aux_o,
  output logic               cs_pass_o,
  output logic               cs_pio_o,
  output logic [1:0]         pio_reg_o,
  output logic [CARD_AW-1:0] card_addr_o,
  output logic [SRAM_AW-1:0] sram_addr_o,
  output logic               rom_en_o
);
  logic                  active, on, off, src_wr, rom_on, rom_off;
  win_src_e              src_sel, src;
  logic [PAGE_BYTES-1:0] pg_wr;
  logic [PAGE_W-1:0]     page;

  ewc_trig_decode #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_trig (
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .active_i (active),
    .on_o     (on),
    .off_o    (off),
    .src_wr_o (src_wr),
    .src_sel_o(src_sel),
    .pg_wr_o  (pg_wr),
    .rom_on_o (rom_on),
    .rom_off_o(rom_off)
  );

  ewc_mode_regs #(.DW(DW), .PAGE_BYTES(PAGE_BYTES)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .wr_i     (wr_i),
    .on_i     (on),
    .off_i    (off),
    .src_wr_i (src_wr),
    .src_sel_i(src_sel),
    .pg_wr_i  (pg_wr),
    .rom_on_i (rom_on),
    .rom_off_i(rom_off),
    .active_o (active),
    .src_o    (src),
    .page_o   (page),
    .rom_en_o (rom_en_o)
  );

  ewc_route #(.AW(AW), .WIN_W(DW), .PAGE_W(PAGE_W), .SRAM_AW(SRAM_AW)) u_route (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .bus_i      (rd_i || wr_i),
    .active_i   (active),
    .direct_i   (direct_i),
    .src_i      (src),
    .page_i     (page),
    .cs_sram_o  (cs_sram_o),
    .cs_card_o  (cs_card_o),
    .cs_aux_o   (cs_aux_o),
    .cs_pass_o  (cs_pass_o),
    .cs_pio_o   (cs_pio_o),
    .pio_reg_o  (pio_reg_o),
    .card_addr_o(card_addr_o),
    .sram_addr_o(sram_addr_o)
  );
endmodule

// File: tb/exp_window_ctrl_bench.sv
`timescale 1ns/1ps
module exp_window_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0, direct_i = 1'b0;
  logic        cs_sram_o, cs_card_o, cs_aux_o, cs_pass_o, cs_pio_o, rom_en_o;
  logic [1:0]  pio_reg_o;
  logic [23:0] card_addr_o;
  logic [12:0] sram_addr_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model of configuration
  bit          m_act = 0, m_rom = 0;
  int          m_src = 0;
  logic [15:0] m_page = '0;

  always #2 clk_i = ~clk_i;

  exp_window_ctrl u_exp_window_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .data_i(data_i),
    .wr_i(wr_i), .rd_i(rd_i), .direct_i(direct_i),
    .cs_sram_o(cs_sram_o), .cs_card_o(cs_card_o), .cs_aux_o(cs_aux_o),
    .cs_pass_o(cs_pass_o), .cs_pio_o(cs_pio_o), .pio_reg_o(pio_reg_o),
    .card_addr_o(card_addr_o), .sram_addr_o(sram_addr_o), .rom_en_o(rom_en_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // bit order {pio, pass, aux, card, sram}
  function automatic logic [4:0] exp_cs(input logic [15:0] a, input bit bus);
    if (!bus || a[15:9] != 7'h6F) return 5'b0;
    if (!m_act) return direct_i ? 5'b00100 : 5'b01000;
    if (!a[8]) return 5'b1 << m_src;
    if (a[7:0] <= 8'h0A) return 5'b00100;
    if (a[7:2] == 6'h10) return 5'b10000;
    return 5'b0;
  endfunction

  function automatic string tag_of(input logic [15:0] a);
    if (a[15:9] != 7'h6F) return "R11";
    if (!m_act) return "R3";
    if (!a[8]) return "R4";
    if (a[7:0] <= 8'h0A) return "R8";
    if (a[7:2] == 6'h10) return "R9";
    return "R11";
  endfunction

  task automatic wr_cyc(input logic [15:0] a, input logic [7:0] d);
    bit old_act;
    @(negedge clk_i);
    rd_i = 1'b0; addr_i = a; data_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
    old_act = m_act;
    if (a == 16'hDF7E) m_act = 1;
    if (a == 16'hDF7F) m_act = 0;
    if (old_act) begin
      if (a[15:2] == 14'h37F0) m_src = int'(a[1:0]);
      if (a == 16'hDFA0) m_page[7:0] = d;
      if (a == 16'hDFA1) m_page[15:8] = d;
      if (a == 16'hDF60) m_rom = 1;
      if (a == 16'hDF70) m_rom = 0;
    end
  endtask

  task automatic probe(input logic [15:0] a, input bit bus);
    logic [4:0] e;
    @(negedge clk_i);
    wr_i = 1'b0; addr_i = a; rd_i = bus;
    #1;
    e = exp_cs(a, bus);
    chk({27'b0, cs_pio_o, cs_pass_o, cs_aux_o, cs_card_o, cs_sram_o}, {27'b0, e}, tag_of(a));
    if (e[1]) chk({8'b0, card_addr_o}, {8'b0, m_page, a[7:0]}, "R5");
    if (e[0]) chk({19'b0, sram_addr_o}, {24'b0, a[7:0]}, "R6");
    if (e[4]) chk({30'b0, pio_reg_o}, {30'b0, a[1:0]}, "R9");
  endtask

  task automatic sweep();
    for (int a = 0; a < 512; a++) probe(16'hDE00 + 16'(a), 1'b1);
    probe(16'h0000, 1'b1);
    probe(16'hDDFF, 1'b1);
    probe(16'hE000, 1'b1);
    probe(16'hFFFF, 1'b1);
    probe(16'hDE00, 1'b0);  // R11 idle bus
    probe(16'hDF40, 1'b0);
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk({31'b0, rom_en_o}, 32'd0, "R1");
    probe(16'hDE00, 1'b1);
    chk({31'b0, cs_pass_o}, 32'd1, "R1");
    chk({8'b0, card_addr_o}, 32'h0, "R1");
    // R4/R7/R5 writes while off are ignored
    wr_cyc(16'hDFC1, 8'h01);
    wr_cyc(16'hDF60, 8'h00);
    wr_cyc(16'hDFA0, 8'h77);
    chk({31'b0, rom_en_o}, 32'd0, "R7");
    sweep();
    direct_i = 1'b1;
    sweep();
    direct_i = 1'b0;
    // R10 read of trigger while off
    probe(16'hDF7E, 1'b1);
    probe(16'hDE00, 1'b1);
    chk({31'b0, cs_pass_o}, 32'd1, "R10");
    // R2 turn on with zero data
    wr_cyc(16'hDF7E, 8'h00);
    probe(16'hDE05, 1'b1);
    chk({31'b0, cs_sram_o}, 32'd1, "R1");
    probe(16'hDE05, 1'b1);
    chk({8'b0, card_addr_o}, 32'h000005, "R4");
    sweep();
    wr_cyc(16'hDFA0, 8'h34);
    wr_cyc(16'hDFA1, 8'h12);
    wr_cyc(16'hDFC1, 8'hA5);
    probe(16'hDE56, 1'b1);
    chk({8'b0, card_addr_o}, 32'h123456, "R5");
    chk({31'b0, cs_card_o}, 32'd1, "R4");
    sweep();
    wr_cyc(16'hDFC2, 8'hFF);
    sweep();
    wr_cyc(16'hDFC3, 8'h3C);
    sweep();
    wr_cyc(16'hDFC0, 8'h00);
    sweep();
    // R10 reads of triggers while on
    probe(16'hDFC1, 1'b1);
    probe(16'hDFA0, 1'b1);
    probe(16'hDF7F, 1'b1);
    probe(16'hDE00, 1'b1);
    chk({31'b0, cs_sram_o}, 32'd1, "R10");
    wr_cyc(16'hDFA0, 8'hFF);
    wr_cyc(16'hDFA1, 8'hFF);
    wr_cyc(16'hDFC1, 8'h00);
    probe(16'hDEFF, 1'b1);
    chk({8'b0, card_addr_o}, 32'hFFFFFF, "R5");
    // R7 ROM enable
    wr_cyc(16'hDF60, 8'h00);
    chk({31'b0, rom_en_o}, 32'd1, "R7");
    probe(16'hDF70, 1'b1);
    chk({31'b0, rom_en_o}, 32'd1, "R10");
    wr_cyc(16'hDF70, 8'hFF);
    chk({31'b0, rom_en_o}, 32'd0, "R7");
    // R2 off/on keeps source, data ignored
    wr_cyc(16'hDF7F, 8'hFF);
    probe(16'hDE00, 1'b1);
    chk({31'b0, cs_pass_o}, 32'd1, "R2");
    wr_cyc(16'hDF7E, 8'h5A);
    probe(16'hDE00, 1'b1);
    chk({31'b0, cs_card_o}, 32'd1, "R2");
    direct_i = 1'b1;
    sweep();
    direct_i = 1'b0;
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R11 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule